// File: doc/BRIEF.md
# Branch and Stack Control Unit

This block is the control-flow stage of a small 8-bit processor. Each cycle it takes an already decoded control operation, the current program counter, a target address, the four status flags and a data byte. From these it produces the next program counter. It also drives the memory-side signals for stack traffic: address, write data, write strobe and read strobe. It keeps the stack pointer in a register of its own. Instruction decoding, the ALU and the memory array sit outside the block.

The operations are an unconditional jump, eight flag-conditional jumps, subroutine call and return, and data push and pop. The stack lives in the same 256-byte space as everything else. It starts at the top of that space and grows toward lower addresses. A call stores the return address in a single byte. A return uses two cycles. The first cycle issues the read and holds the pipeline. The second cycle loads the program counter from the byte the memory returns, which arrives one cycle after its address (a synchronous read).

Top module: `branch_stack_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied, the stack pointer becomes 0xFF, and after release `stall_o` is low with neither strobe active until an operation requests one.
- R2: Operation codes are 0 idle, 1 jump, 2 jump-if-zero, 3 jump-if-not-zero, 4 jump-if-carry, 5 jump-if-no-carry, 6 jump-if-negative, 7 jump-if-positive, 8 jump-if-overflow, 9 jump-if-no-overflow, 10 call, 11 return, 12 push, 13 pop; 14 and 15 act as idle. Code 1 always sets `pc_next_o` to `target_i`.
- R3: Flags are `flags_i[0]` zero, `[1]` negative, `[2]` carry, `[3]` overflow. Codes 2/4/6/8 are taken when their flag is 1 and codes 3/5/7/9 when it is 0; a taken jump sets `pc_next_o` to `target_i`.
- R4: An untaken conditional jump, an idle code, a push and a pop all set `pc_next_o` to `pc_i + 2` modulo 256.
- R5: A push writes `push_data_i` at the address equal to the current stack pointer, and the pointer is one lower on the next cycle.
- R6: A pop raises the read strobe with address stack pointer + 1 and no write, and the pointer equals that address on the next cycle.
- R7: A call writes `pc_i + 2` at the current stack pointer, sets `pc_next_o` to `target_i`, and lowers the pointer by one.
- R8: A return raises the read strobe at stack pointer + 1, raises `stall_o`, holds `pc_next_o` at `pc_i` and raises the pointer. In the following cycle it sets `pc_next_o` to `mem_rdata_i`, with no strobes and no pointer change, whatever operation is presented.
- R9: The stack pointer and the incremented program counter wrap modulo 256 with no fault. A pop at 0xFF reads address 0x00, and a push at 0x00 leaves the pointer at 0xFF.
- R10: Nested calls return in last-in first-out order, each return landing at its own call's address + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Decoded control operation code |
| flags_i | input | 4 | Status flags: zero, negative, carry, overflow (bit 0 upward) |
| target_i | input | 8 | Jump or call target address |
| pc_i | input | 8 | Address of the current instruction |
| push_data_i | input | 8 | Byte stored by a push |
| mem_rdata_i | input | 8 | Byte returned by memory one cycle after a read |
| pc_next_o | output | 8 | Program counter for the next instruction |
| stall_o | output | 1 | First cycle of a return; the fetch must hold |
| mem_addr_o | output | 8 | Stack access address |
| mem_wdata_o | output | 8 | Stack write data |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| sp_o | output | 8 | Current stack pointer |

## Verification
The bound checker watches the pointer bookkeeping on every cycle. After each write strobe the pointer must step down by one. After each read strobe the pointer must equal the address just read. With no strobe it must not move. Writes must always land at the pointer, the two strobes must never be active together, and a stalled cycle must always be followed by a load of the program counter from the returned byte. The outcome of each jump condition under given flags, the exact return address a call stores, LIFO order across nested calls, and the wrap at the ends of the space all depend on operation sequences. Only the bench shows these, by comparing every cycle against its own model of the stack and its own memory.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [3:0] {
      OP_IDLE = 4'd0,
      OP_JMP  = 4'd1,
      OP_JZ   = 4'd2,
      OP_JNZ  = 4'd3,
      OP_JC   = 4'd4,
      OP_JNC  = 4'd5,
      OP_JN   = 4'd6,
      OP_JP   = 4'd7,
      OP_JV   = 4'd8,
      OP_JNV  = 4'd9,
      OP_CALL = 4'd10,
      OP_RET  = 4'd11,
      OP_PUSH = 4'd12,
      OP_POP  = 4'd13
   } bsc_op_e;

   typedef struct packed {
      logic ovf;
      logic carry;
      logic neg;
      logic zero;
   } bsc_flags_t;

endpackage

// File: rtl/bsc_cond_eval.sv
module bsc_cond_eval
   import bsc_pkg::*;
(
   input  bsc_op_e    op_i,
   input  bsc_flags_t flags_i,
   output logic       is_jump_o,
   output logic       take_o
);

   always_comb begin
      is_jump_o = 1'b1;
      take_o    = 1'b0;
      unique case (op_i)
         OP_JMP:  take_o = 1'b1;
         OP_JZ:   take_o = flags_i.zero;
         OP_JNZ:  take_o = ~flags_i.zero;
         OP_JC:   take_o = flags_i.carry;
         OP_JNC:  take_o = ~flags_i.carry;
         OP_JN:   take_o = flags_i.neg;
         OP_JP:   take_o = ~flags_i.neg;
         OP_JV:   take_o = flags_i.ovf;
         OP_JNV:  take_o = ~flags_i.ovf;
         default: is_jump_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/bsc_stack_ptr.sv
module bsc_stack_ptr #(
   parameter int             AW        = 8,
   parameter logic [AW-1:0]  SP_INIT   = '1,
   parameter bit             GROW_DOWN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] pop_addr_o
);

   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] sp_q;
   logic [AW-1:0] sp_after_push;
   logic [AW-1:0] sp_after_pop;

   generate
      if (GROW_DOWN) begin : g_down
         assign sp_after_push = sp_q - ONE;
         assign sp_after_pop  = sp_q + ONE;
      end else begin : g_up
         assign sp_after_push = sp_q + ONE;
         assign sp_after_pop  = sp_q - ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_INIT;
      end else if (push_i) begin
         sp_q <= sp_after_push;
      end else if (pop_i) begin
         sp_q <= sp_after_pop;
      end
   end

   assign sp_o       = sp_q;
   assign pop_addr_o = sp_after_pop;

endmodule

// File: rtl/bsc_ret_seq.sv
module bsc_ret_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic ret_issue_i,
   output logic ret_land_o
);

   logic land_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         land_q <= 1'b0;
      end else begin
         land_q <= ret_issue_i;
      end
   end

   assign ret_land_o = land_q;

endmodule

// File: rtl/branch_stack_ctrl.sv
module branch_stack_ctrl
   import bsc_pkg::*;
#(
   parameter int             AW        = 8,
   parameter int             DW        = 8,
   parameter int             INSN_LEN  = 2,
   parameter bit             GROW_DOWN = 1'b1,
   parameter logic [AW-1:0]  SP_INIT   = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_i,
   input  logic [3:0]    flags_i,
   input  logic [AW-1:0] target_i,
   input  logic [AW-1:0] pc_i,
   input  logic [DW-1:0] push_data_i,
   input  logic [DW-1:0] mem_rdata_i,
   output logic [AW-1:0] pc_next_o,
   output logic          stall_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   output logic [AW-1:0] sp_o
);

   localparam logic [AW-1:0] PC_STEP = AW'(INSN_LEN);

   generate
      if (DW < AW) begin : g_bad_width
         $error("branch_stack_ctrl: a return address must fit in one stack word");
      end
      if (INSN_LEN < 1) begin : g_bad_len
         $error("branch_stack_ctrl: instruction length must be at least one");
      end
      if (AW < 2) begin : g_bad_aw
         $error("branch_stack_ctrl: address width too small");
      end
   endgenerate

   bsc_op_e    op;
   bsc_flags_t flags;
   logic       is_jump;
   logic       take;
   logic       ret_land;
   logic       ret_issue;
   logic       push_en;
   logic       pop_en;
   logic [AW-1:0] sp;
   logic [AW-1:0] pop_addr;
   logic [AW-1:0] seq_pc;

   assign op     = bsc_op_e'(op_i);
   assign flags  = bsc_flags_t'(flags_i);
   assign seq_pc = pc_i + PC_STEP;

   bsc_cond_eval u_cond (
      .op_i      (op),
      .flags_i   (flags),
      .is_jump_o (is_jump),
      .take_o    (take)
   );

   bsc_stack_ptr #(
      .AW        (AW),
      .SP_INIT   (SP_INIT),
      .GROW_DOWN (GROW_DOWN)
   ) u_sp (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push_en),
      .pop_i      (pop_en),
      .sp_o       (sp),
      .pop_addr_o (pop_addr)
   );

   bsc_ret_seq u_ret (
      .clk         (clk),
      .rst_n       (rst_n),
      .ret_issue_i (ret_issue),
      .ret_land_o  (ret_land)
   );

   always_comb begin
      pc_next_o   = seq_pc;
      stall_o     = 1'b0;
      mem_addr_o  = sp;
      mem_wdata_o = '0;
      mem_we_o    = 1'b0;
      mem_re_o    = 1'b0;
      push_en     = 1'b0;
      pop_en      = 1'b0;
      ret_issue   = 1'b0;
      if (ret_land) begin
         pc_next_o = mem_rdata_i[AW-1:0];
      end else if (is_jump) begin
         pc_next_o = take ? target_i : seq_pc;
      end else begin
         unique case (op)
            OP_CALL: begin
               mem_we_o    = 1'b1;
               mem_wdata_o = DW'(seq_pc);
               push_en     = 1'b1;
               pc_next_o   = target_i;
            end
            OP_RET: begin
               mem_re_o   = 1'b1;
               mem_addr_o = pop_addr;
               pop_en     = 1'b1;
               ret_issue  = 1'b1;
               stall_o    = 1'b1;
               pc_next_o  = pc_i;
            end
            OP_PUSH: begin
               mem_we_o    = 1'b1;
               mem_wdata_o = push_data_i;
               push_en     = 1'b1;
            end
            OP_POP: begin
               mem_re_o   = 1'b1;
               mem_addr_o = pop_addr;
               pop_en     = 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign sp_o = sp;

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
   import bsc_pkg::*;
#(
   parameter int             AW        = 8,
   parameter int             DW        = 8,
   parameter bit             GROW_DOWN = 1'b1,
   parameter logic [AW-1:0]  SP_INIT   = '1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    op_i,
   input logic [AW-1:0] target_i,
   input logic [DW-1:0] mem_rdata_i,
   input logic [AW-1:0] pc_next_o,
   input logic          stall_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_we_o,
   input logic          mem_re_o,
   input logic [AW-1:0] sp_o
);

   localparam logic [AW-1:0] PUSH_STEP = GROW_DOWN ? {AW{1'b1}} : AW'(1);

   AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (sp_o == SP_INIT && !stall_o)); // R1

   AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> mem_addr_o == sp_o); // R5

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> sp_o == $past(sp_o) + PUSH_STEP); // R5

   AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o)); // R6

   AST_POP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> sp_o == $past(mem_addr_o)); // R6

   AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && op_i == OP_CALL) |-> pc_next_o == target_i); // R7

   AST_RET_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> (!stall_o && !mem_we_o && !mem_re_o && pc_next_o == mem_rdata_i[AW-1:0])); // R8

   AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_o && !mem_re_o) |=> $stable(sp_o)); // R8

endmodule

bind branch_stack_ctrl bsc_checker #(
   .AW        (AW),
   .DW        (DW),
   .GROW_DOWN (GROW_DOWN),
   .SP_INIT   (SP_INIT)
) u_bsc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_i        (op_i),
   .target_i    (target_i),
   .mem_rdata_i (mem_rdata_i),
   .pc_next_o   (pc_next_o),
   .stall_o     (stall_o),
   .mem_addr_o  (mem_addr_o),
   .mem_we_o    (mem_we_o),
   .mem_re_o    (mem_re_o),
   .sp_o        (sp_o)
);

// File: tb/test_branch_stack_ctrl.sv
module test_branch_stack_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic [3:0] flags_i = '0;
   logic [7:0] target_i = '0;
   logic [7:0] pc_i = '0;
   logic [7:0] push_data_i = '0;
   logic [7:0] mem_rdata_i;
   logic [7:0] pc_next_o;
   logic       stall_o;
   logic [7:0] mem_addr_o;
   logic [7:0] mem_wdata_o;
   logic       mem_we_o;
   logic       mem_re_o;
   logic [7:0] sp_o;

   int n_checks = 0;
   int n_errors = 0;
   string tag_ovr = "";

   logic [7:0] bmem [256];
   logic [7:0] mref [256];
   logic [7:0] sp_m;
   logic       pend_m;

   always #4 clk = ~clk;

   branch_stack_ctrl i_branch_stack_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_i        (op_i),
      .flags_i     (flags_i),
      .target_i    (target_i),
      .pc_i        (pc_i),
      .push_data_i (push_data_i),
      .mem_rdata_i (mem_rdata_i),
      .pc_next_o   (pc_next_o),
      .stall_o     (stall_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .mem_we_o    (mem_we_o),
      .mem_re_o    (mem_re_o),
      .sp_o        (sp_o)
   );

   // synchronous-read memory model
   always @(posedge clk) begin
      if (!rst_n) mem_rdata_i <= 8'h00;
      else begin
         if (mem_we_o) bmem[mem_addr_o] <= mem_wdata_o;
         if (mem_re_o) mem_rdata_i <= bmem[mem_addr_o];
      end
   end

   function automatic bit cond_taken(input logic [3:0] op, input logic [3:0] fl);
      case (op)
         4'd1: return 1'b1;
         4'd2: return fl[0] == 1'b1;
         4'd3: return fl[0] == 1'b0;
         4'd4: return fl[2] == 1'b1;
         4'd5: return fl[2] == 1'b0;
         4'd6: return fl[1] == 1'b1;
         4'd7: return fl[1] == 1'b0;
         4'd8: return fl[3] == 1'b1;
         4'd9: return fl[3] == 1'b0;
         default: return 1'b0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] op, input logic [3:0] fl, input logic pend);
      if (pend) return "R8";
      case (op)
         4'd1: return "R2";
         4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
            return cond_taken(op, fl) ? "R3" : "R4";
         4'd10: return "R7";
         4'd11: return "R8";
         4'd12: return "R5";
         4'd13: return "R6";
         default: return "R4";
      endcase
   endfunction

   task automatic step(input logic [3:0] op, input logic [7:0] tgt, input logic [7:0] pc,
                       input logic [3:0] fl, input logic [7:0] d);
      logic [7:0] e_pc, e_addr, e_wd, e_sp_next;
      logic e_we, e_re, e_stall;
      bit ok;
      string tag;
      @(negedge clk);
      op_i = op; target_i = tgt; pc_i = pc; flags_i = fl; push_data_i = d;
      #2;
      e_we = 1'b0; e_re = 1'b0; e_stall = 1'b0; e_addr = 8'h00; e_wd = 8'h00;
      e_sp_next = sp_m;
      e_pc = pc + 8'd2;
      if (pend_m) begin
         e_pc = mref[sp_m];
      end else begin
         case (op)
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
               if (cond_taken(op, fl)) e_pc = tgt;
            4'd10: begin
               e_we = 1'b1; e_addr = sp_m; e_wd = pc + 8'd2; e_pc = tgt; e_sp_next = sp_m - 8'd1;
            end
            4'd11: begin
               e_re = 1'b1; e_addr = sp_m + 8'd1; e_stall = 1'b1; e_pc = pc; e_sp_next = sp_m + 8'd1;
            end
            4'd12: begin
               e_we = 1'b1; e_addr = sp_m; e_wd = d; e_sp_next = sp_m - 8'd1;
            end
            4'd13: begin
               e_re = 1'b1; e_addr = sp_m + 8'd1; e_sp_next = sp_m + 8'd1;
            end
            default: ;
         endcase
      end
      ok = (pc_next_o === e_pc) && (mem_we_o === e_we) && (mem_re_o === e_re) &&
           (stall_o === e_stall) && (sp_o === sp_m) &&
           (!(e_we || e_re) || mem_addr_o === e_addr) && (!e_we || mem_wdata_o === e_wd);
      tag = (tag_ovr != "") ? tag_ovr : req_of(op, fl, pend_m);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s op=%0d fl=%h: got pc=%h we=%b re=%b addr=%h wd=%h sp=%h stall=%b, expected pc=%h we=%b re=%b addr=%h wd=%h sp=%h stall=%b",
                  tag, op, fl, pc_next_o, mem_we_o, mem_re_o, mem_addr_o, mem_wdata_o, sp_o, stall_o,
                  e_pc, e_we, e_re, e_addr, e_wd, sp_m, e_stall);
      end
      if (e_we) mref[e_addr] = e_wd;
      sp_m   = e_sp_next;
      pend_m = e_stall;
   endtask

   initial begin
      #(8 * 200000);
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < 256; i++) begin
         bmem[i] = 8'h00;
         mref[i] = 8'h00;
      end
      sp_m = 8'hFF;
      pend_m = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: reset state
      n_checks++;
      if (sp_o !== 8'hFF || stall_o !== 1'b0 || mem_we_o !== 1'b0 || mem_re_o !== 1'b0) begin
         n_errors++;
         $display("FAIL R1: got sp=%h stall=%b we=%b re=%b, expected sp=ff stall=0 we=0 re=0",
                  sp_o, stall_o, mem_we_o, mem_re_o);
      end

      // R9: pop at top wraps to address 0, push at 0 wraps back to FF
      tag_ovr = "R9";
      step(4'd13, 8'h00, 8'h20, 4'h0, 8'h00);
      step(4'd12, 8'h00, 8'h22, 4'h0, 8'h5A);
      step(4'd12, 8'h00, 8'h24, 4'h0, 8'hA5);
      step(4'd13, 8'h00, 8'h26, 4'h0, 8'h00);
      step(4'd0,  8'h00, 8'hFF, 4'h0, 8'h00);   // pc wrap FF+2 -> 01
      step(4'd3,  8'h90, 8'hFE, 4'h1, 8'h00);   // untaken jump at top of space
      tag_ovr = "";

      // R2 R3 R4: every jump code with several flag patterns
      for (int op = 1; op <= 9; op++) begin
         for (int f = 0; f < 6; f++) begin
            logic [3:0] fl;
            fl = (f == 0) ? 4'h0 : (f == 5) ? 4'hF : 4'(1 << (f - 1));
            step(4'(op), 8'(8'h30 + op), 8'(8'h10 * f), fl, 8'h00);
         end
      end
      // idle-like codes 14 and 15 (R4)
      step(4'd14, 8'h77, 8'h40, 4'hF, 8'h00);
      step(4'd15, 8'h77, 8'h42, 4'h0, 8'h00);

      // R10: three nested calls then three returns, LIFO
      tag_ovr = "R10";
      step(4'd10, 8'h40, 8'h10, 4'h0, 8'h00);
      step(4'd10, 8'h80, 8'h40, 4'h0, 8'h00);
      step(4'd10, 8'hC0, 8'h80, 4'h0, 8'h00);
      step(4'd11, 8'h00, 8'hC0, 4'h0, 8'h00);
      step(4'd0,  8'h00, 8'hC0, 4'h0, 8'h00);   // lands at 82
      step(4'd11, 8'h00, 8'h82, 4'h0, 8'h00);
      step(4'd0,  8'h00, 8'h82, 4'h0, 8'h00);   // lands at 42
      step(4'd11, 8'h00, 8'h42, 4'h0, 8'h00);
      step(4'd0,  8'h00, 8'h42, 4'h0, 8'h00);   // lands at 12
      tag_ovr = "";

      // R8: operation presented in the landing cycle is ignored
      step(4'd10, 8'h60, 8'h50, 4'h0, 8'h00);
      step(4'd11, 8'h00, 8'h60, 4'h0, 8'h00);
      step(4'd12, 8'h99, 8'h60, 4'h0, 8'hEE);
      step(4'd13, 8'h00, 8'h52, 4'h0, 8'h00);   // pop sees unchanged pointer

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [3:0] op;
         op = 4'($urandom_range(0, 15));
         step(op, 8'($urandom), 8'($urandom), 4'($urandom_range(0, 15)), 8'($urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule